// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the arithmetic and logic stage of a simple load/store RISC pipeline. Each cycle it may accept one already-decoded operation with two register operands, a 16-bit immediate and a 5-bit constant shift amount. One clock later it presents the 32-bit result, a trap flag for two's-complement overflow, and a write enable for the destination register. The write enable is withheld when the trap fires.

The operation set covers:
- add and subtract, in trapping and non-trapping forms;
- signed and unsigned set-less-than, with register or immediate operands;
- four bitwise functions, including NOR;
- shifts by a constant amount or by a register amount;
- load-upper-immediate.

The unit chooses zero or sign extension of the immediate from the operation itself. The surrounding decoder therefore only supplies the raw 16-bit field.

Top module: `exu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_ovf` and `out_wr_en` become 0 and `out_result` becomes 0.
- R2: `out_valid` equals `in_valid` from the previous clock. After a cycle with `in_valid` low, `out_ovf` and `out_wr_en` are 0 and `out_result` keeps its previous value.
- R3: Ops ADD (0), SUB (2) and ADDI (4) yield the low 32 bits of the sum `a+b`, `a-b` or `a+sext(imm)` respectively. They set `out_ovf` exactly when the true signed result lies outside -2^31..2^31-1.
- R4: Ops ADDU (1), SUBU (3) and ADDIU (5) yield the same wrapped sums as their trapping counterparts. `out_ovf` is 0 for every operation other than those named in R3.
- R5: `out_wr_en` is 1 for a valid operation exactly when `out_ovf` is 0. A trapping overflow therefore suppresses writeback, while `out_result` still shows the wrapped sum.
- R6: ANDI (14), ORI (15) and XORI (16) apply AND, OR or XOR between `src_a` and the immediate zero-extended to 32 bits.
- R7: ADDI, ADDIU (5), SLTI (8) and SLTIU (9) sign-extend the immediate. SLTIU then compares that extended value as an unsigned number.
- R8: SLT (6) and SLTI give 1 when `src_a` is below the second operand as two's complement. SLTU (7) and SLTIU do the same for unsigned magnitudes. In every other case these ops give 0, so bits 31:1 are always 0.
- R9: SLL (17), SRL (18) and SRA (19) shift `src_a` by `shamt`. SLLV (20), SRLV (21) and SRAV (22) shift `src_a` by `src_b[4:0]`, and the upper bits of `src_b` are ignored. Arithmetic right shifts fill with `src_a[31]`; the others fill with 0.
- R10: AND (10), OR (11), XOR (12) and NOR (13) operate bitwise on `src_a` and `src_b`. NOR with a zero `src_b` gives `~src_a`.
- R11: LUI (23) gives `{imm, 16'h0000}`.
- R12: Op codes 24 to 31 give a result of 0, with `out_ovf` 0 and `out_wr_en` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Decoded operation code (values in R3 to R12) |
| src_a | input | 32 | First register operand; also the value that is shifted |
| src_b | input | 32 | Second register operand; also the variable shift amount |
| imm | input | 16 | Raw immediate field |
| shamt | input | 5 | Constant shift amount |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Registered result |
| out_ovf | output | 1 | Overflow trap for the trapping add and subtract forms |
| out_wr_en | output | 1 | Destination write enable, low when a trap fires |

## Verification
The hardest behaviour to reach is the exact edge of signed overflow. Operand pairs next to 0x7FFFFFFF and 0x80000000 decide whether the trap fires, and they also decide whether the signed compare must correct its sign using the overflow term. Uniform random operands almost never land there. The stimulus therefore includes directed cases for both edges in every trapping and compare form. Random operands are drawn half the time from a small set of corner values, so that sums cross the sign boundary often, and each result is checked against a model that uses 64-bit arithmetic.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_SLT   = 5'd6,  OP_SLTU  = 5'd7,
    OP_SLTI  = 5'd8,  OP_SLTIU = 5'd9,  OP_AND   = 5'd10, OP_OR    = 5'd11,
    OP_XOR   = 5'd12, OP_NOR   = 5'd13, OP_ANDI  = 5'd14, OP_ORI   = 5'd15,
    OP_XORI  = 5'd16, OP_SLL   = 5'd17, OP_SRL   = 5'd18, OP_SRA   = 5'd19,
    OP_SLLV  = 5'd20, OP_SRLV  = 5'd21, OP_SRAV  = 5'd22, OP_LUI   = 5'd23
  } exu_op_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} logic_kind_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARI} shift_kind_e;
endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  exu_op_e         op,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] imm_x
);
  localparam int PADW = XLEN - IMMW;

  logic zero_ext;

  // Only the bitwise immediate forms use zero extension.
  assign zero_ext = (op == OP_ANDI) || (op == OP_ORI) || (op == OP_XORI);

  always_comb begin
    if (zero_ext) imm_x = {{PADW{1'b0}}, imm};
    else          imm_x = {{PADW{imm[IMMW-1]}}, imm};
  end
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] sum,
  output logic            sovf,
  output logic            lt_s,
  output logic            lt_u
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] bx;
  logic [XLEN:0]   full;

  assign bx   = b ^ {XLEN{sub}};
  assign full = {1'b0, a} + {1'b0, bx} + {{XLEN{1'b0}}, sub};
  assign sum  = full[MSB:0];
  // Equal addend signs with a flipped result sign means overflow.
  assign sovf = (a[MSB] == bx[MSB]) && (sum[MSB] != a[MSB]);
  // Compare forms run in subtract mode.
  assign lt_s = sum[MSB] ^ sovf;
  assign lt_u = ~full[XLEN];
endmodule

// File: rtl/exu_logic.sv
module exu_logic
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic_kind_e     kind,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (kind)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/exu_shift.sv
module exu_shift
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val,
  input  logic [SHW-1:0]  amt,
  input  shift_kind_e     kind,
  output logic [XLEN-1:0] y
);
  logic                    left;
  logic                    fill;
  logic [SHW:0][XLEN-1:0]  stg;

  assign left = (kind == SH_LEFT);
  assign fill = (kind == SH_RARI) & val[XLEN-1];

  // A left shift is a right shift of the mirrored word, mirrored back.
  for (genvar i = 0; i < XLEN; i++) begin : g_mirror
    assign stg[0][i] = left ? val[XLEN-1-i] : val[i];
    assign y[i]      = left ? stg[SHW][XLEN-1-i] : stg[SHW][i];
  end

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][XLEN-1:D]} : stg[s];
  end
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [IMMW-1:0] imm,
  input  logic [SHW-1:0]  shamt,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_ovf,
  output logic            out_wr_en
);
  localparam int LOW0 = XLEN - IMMW;

  exu_op_e         opc;
  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] lg_res;
  logic [XLEN-1:0] sh_res;
  logic [XLEN-1:0] res_c;
  logic            do_sub;
  logic            use_imm;
  logic            trap_en;
  logic            var_sh;
  logic            sovf;
  logic            lt_s;
  logic            lt_u;
  logic            trap_c;
  logic_kind_e     lk;
  shift_kind_e     sk;
  logic [SHW-1:0]  sh_amt;

  assign opc = exu_op_e'(op);

  exu_imm_ext #(.XLEN(XLEN), .IMMW(IMMW)) u_imm (
    .op(opc), .imm(imm), .imm_x(imm_x)
  );

  // Decode of operand routing.
  always_comb begin
    do_sub  = 1'b0;
    use_imm = 1'b0;
    trap_en = 1'b0;
    var_sh  = 1'b0;
    lk      = LG_AND;
    sk      = SH_LEFT;
    case (opc)
      OP_ADD:   trap_en = 1'b1;
      OP_SUB:   begin trap_en = 1'b1; do_sub = 1'b1; end
      OP_SUBU:  do_sub = 1'b1;
      OP_ADDI:  begin trap_en = 1'b1; use_imm = 1'b1; end
      OP_ADDIU: use_imm = 1'b1;
      OP_SLT, OP_SLTU:   do_sub = 1'b1;
      OP_SLTI, OP_SLTIU: begin do_sub = 1'b1; use_imm = 1'b1; end
      OP_OR:    lk = LG_OR;
      OP_XOR:   lk = LG_XOR;
      OP_NOR:   lk = LG_NOR;
      OP_ANDI:  use_imm = 1'b1;
      OP_ORI:   begin use_imm = 1'b1; lk = LG_OR; end
      OP_XORI:  begin use_imm = 1'b1; lk = LG_XOR; end
      OP_SRL:   sk = SH_RLOG;
      OP_SRA:   sk = SH_RARI;
      OP_SLLV:  var_sh = 1'b1;
      OP_SRLV:  begin var_sh = 1'b1; sk = SH_RLOG; end
      OP_SRAV:  begin var_sh = 1'b1; sk = SH_RARI; end
      default: ;
    endcase
  end

  assign opnd_b = use_imm ? imm_x : src_b;
  assign sh_amt = var_sh ? src_b[SHW-1:0] : shamt;

  exu_addsub #(.XLEN(XLEN)) u_add (
    .a(src_a), .b(opnd_b), .sub(do_sub),
    .sum(sum), .sovf(sovf), .lt_s(lt_s), .lt_u(lt_u)
  );

  exu_logic #(.XLEN(XLEN)) u_lg (
    .a(src_a), .b(opnd_b), .kind(lk), .y(lg_res)
  );

  exu_shift #(.XLEN(XLEN)) u_sh (
    .val(src_a), .amt(sh_amt), .kind(sk), .y(sh_res)
  );

  // Result select.
  always_comb begin
    case (opc)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_ADDI, OP_ADDIU:
        res_c = sum;
      OP_SLT, OP_SLTI:
        res_c = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU:
        res_c = {{(XLEN-1){1'b0}}, lt_u};
      OP_AND, OP_OR, OP_XOR, OP_NOR, OP_ANDI, OP_ORI, OP_XORI:
        res_c = lg_res;
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV:
        res_c = sh_res;
      OP_LUI:
        res_c = {imm, {LOW0{1'b0}}};
      default:
        res_c = '0;
    endcase
  end

  assign trap_c = trap_en & sovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_wr_en  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_ovf   <= in_valid & trap_c;
      out_wr_en <= in_valid & ~trap_c;
      if (in_valid) out_result <= res_c;
    end
  end
endmodule

// File: rtl/exu_chk.sv
module exu_chk
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [OPW-1:0]  op,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_ovf,
  input logic            out_wr_en
);
  logic unsigned_sum;
  logic cmp_op;
  logic lui_op;

  assign unsigned_sum = (op == OP_ADDU) || (op == OP_SUBU) || (op == OP_ADDIU);
  assign cmp_op = (op == OP_SLT) || (op == OP_SLTU) || (op == OP_SLTI) || (op == OP_SLTIU);
  assign lui_op = (op == OP_LUI);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_ovf && !out_wr_en));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unsigned_sum) |=> !out_ovf);

  assert_trap_blocks_wb_R5: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_valid && !out_wr_en));

  assert_cmp_one_bit_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cmp_op) |=> (out_result[XLEN-1:1] == '0));

  assert_lui_low_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lui_op) |=> (out_result[XLEN-IMMW-1:0] == '0));
endmodule

bind exu_top exu_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .out_result(out_result),
  .out_ovf(out_ovf), .out_wr_en(out_wr_en)
);

// File: tb/sim_exu_top.sv
module sim_exu_top;
  import exu_pkg::*;

  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_ovf;
  logic        out_wr_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] held = '0;

  always #2 clk = ~clk;

  exu_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
    .out_valid(out_valid), .out_result(out_result),
    .out_ovf(out_ovf), .out_wr_en(out_wr_en)
  );

  function automatic string req_of(input logic [4:0] o);
    case (o)
      OP_ADD, OP_SUB, OP_ADDI:           return "R3";
      OP_ADDU, OP_SUBU:                  return "R4";
      OP_ADDIU, OP_SLTI, OP_SLTIU:       return "R7";
      OP_SLT, OP_SLTU:                   return "R8";
      OP_ANDI, OP_ORI, OP_XORI:          return "R6";
      OP_AND, OP_OR, OP_XOR, OP_NOR:     return "R10";
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:         return "R9";
      OP_LUI:                            return "R11";
      default:                           return "R12";
    endcase
  endfunction

  function automatic void model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [4:0] sh,
                                output logic [31:0] r, output logic ov);
    logic [31:0] sx;
    logic [31:0] zx;
    longint wide;
    sx = {{16{im[15]}}, im};
    zx = {16'h0000, im};
    ov = 1'b0;
    r  = 32'h0;
    case (o)
      OP_ADD, OP_ADDU: begin
        r = a + b;
        wide = longint'($signed(a)) + longint'($signed(b));
        ov = (o == OP_ADD) && (wide > SMAX || wide < SMIN);
      end
      OP_SUB, OP_SUBU: begin
        r = a - b;
        wide = longint'($signed(a)) - longint'($signed(b));
        ov = (o == OP_SUB) && (wide > SMAX || wide < SMIN);
      end
      OP_ADDI, OP_ADDIU: begin
        r = a + sx;
        wide = longint'($signed(a)) + longint'($signed(sx));
        ov = (o == OP_ADDI) && (wide > SMAX || wide < SMIN);
      end
      OP_SLT:   r = {31'h0, $signed(a) < $signed(b)};
      OP_SLTU:  r = {31'h0, a < b};
      OP_SLTI:  r = {31'h0, $signed(a) < $signed(sx)};
      OP_SLTIU: r = {31'h0, a < sx};
      OP_AND:   r = a & b;
      OP_OR:    r = a | b;
      OP_XOR:   r = a ^ b;
      OP_NOR:   r = ~(a | b);
      OP_ANDI:  r = a & zx;
      OP_ORI:   r = a | zx;
      OP_XORI:  r = a ^ zx;
      OP_SLL:   r = a << sh;
      OP_SRL:   r = a >> sh;
      OP_SRA:   r = $unsigned($signed(a) >>> sh);
      OP_SLLV:  r = a << b[4:0];
      OP_SRLV:  r = a >> b[4:0];
      OP_SRAV:  r = $unsigned($signed(a) >>> b[4:0]);
      OP_LUI:   r = {im, 16'h0000};
      default:  r = 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, compare at the next falling edge.
  task automatic step(input logic v, input logic [4:0] o, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] er;
    logic eo;
    in_valid = v; op = o; src_a = a; src_b = b; imm = im; shamt = sh;
    model(o, a, b, im, sh, er, eo);
    @(negedge clk);
    check("R2", "out_valid", {31'h0, out_valid}, {31'h0, v});
    if (v) begin
      check(req_of(o), "out_result", out_result, er);
      check(eo ? "R3" : "R4", "out_ovf", {31'h0, out_ovf}, {31'h0, eo});
      check("R5", "out_wr_en", {31'h0, out_wr_en}, {31'h0, ~eo});
      held = er;
    end else begin
      check("R2", "held out_result", out_result, held);
      check("R2", "idle out_ovf", {31'h0, out_ovf}, 32'h0);
      check("R2", "idle out_wr_en", {31'h0, out_wr_en}, 32'h0);
    end
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] c [7];
    c = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h80000001, 32'h7FFFFFFE};
    if ($urandom_range(0, 1) == 0) return c[$urandom_range(0, 6)];
    return $urandom();
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1", "reset out_valid", {31'h0, out_valid}, 32'h0);
    check("R1", "reset out_result", out_result, 32'h0);
    check("R1", "reset out_ovf", {31'h0, out_ovf}, 32'h0);
    check("R1", "reset out_wr_en", {31'h0, out_wr_en}, 32'h0);
    rst = 1'b0;

    // R3 boundaries of signed overflow
    step(1, OP_ADD,  32'h7FFFFFFF, 32'h00000001, 16'h0, 5'd0);
    step(1, OP_ADD,  32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0);
    step(1, OP_ADD,  32'h7FFFFFFE, 32'h00000001, 16'h0, 5'd0);
    step(1, OP_SUB,  32'h80000000, 32'h00000001, 16'h0, 5'd0);
    step(1, OP_SUB,  32'h00000000, 32'h80000000, 16'h0, 5'd0);
    step(1, OP_SUB,  32'hFFFFFFFF, 32'h80000000, 16'h0, 5'd0);
    step(1, OP_ADDI, 32'h7FFFFFF0, 32'h0, 16'h0010, 5'd0);
    step(1, OP_ADDI, 32'h80000000, 32'h0, 16'hFFFF, 5'd0);
    // R4 same sums without a trap
    step(1, OP_ADDU,  32'h7FFFFFFF, 32'h00000001, 16'h0, 5'd0);
    step(1, OP_SUBU,  32'h00000000, 32'h80000000, 16'h0, 5'd0);
    step(1, OP_ADDIU, 32'h7FFFFFF0, 32'h0, 16'h0010, 5'd0);
    // R7 sign extension of the immediate
    step(1, OP_ADDIU, 32'h00000000, 32'h0, 16'hFFFF, 5'd0);
    step(1, OP_SLTIU, 32'h00000005, 32'h0, 16'hFFFF, 5'd0);
    step(1, OP_SLTI,  32'h00000005, 32'h0, 16'hFFFF, 5'd0);
    // R8 compares, including a difference that overflows
    step(1, OP_SLT,  32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0);
    step(1, OP_SLTU, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0);
    step(1, OP_SLT,  32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);
    step(1, OP_SLT,  32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd0);
    step(1, OP_SLTU, 32'h00000003, 32'h00000003, 16'h0, 5'd0);
    // R6 zero extension of the immediate
    step(1, OP_ANDI, 32'hF234012F, 32'h0, 16'h00FF, 5'd0);
    step(1, OP_ORI,  32'hFFFF0000, 32'h0, 16'h8000, 5'd0);
    step(1, OP_XORI, 32'h00000000, 32'h0, 16'hFFFF, 5'd0);
    // R10 logic and NOR as inverter
    step(1, OP_NOR, 32'h12345678, 32'h00000000, 16'h0, 5'd0);
    step(1, OP_OR,  32'hF2340000, 32'h000012BC, 16'h0, 5'd0);
    // R9 shifts, constant and variable
    step(1, OP_SLL,  32'h00000001, 32'h0, 16'h0, 5'd31);
    step(1, OP_SRA,  32'h80000000, 32'h0, 16'h0, 5'd4);
    step(1, OP_SRL,  32'h80000000, 32'h0, 16'h0, 5'd4);
    step(1, OP_SRAV, 32'h80000000, 32'h00000024, 16'h0, 5'd0);
    step(1, OP_SLLV, 32'h00000003, 32'hFFFFFFE1, 16'h0, 5'd9);
    step(1, OP_SRLV, 32'hF0000000, 32'h0000001F, 16'h0, 5'd0);
    // R11 load upper immediate
    step(1, OP_LUI, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFEDC, 5'd7);
    // R12 unassigned codes
    step(1, 5'd31, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 5'd3);
    step(1, 5'd24, 32'h12345678, 32'h9, 16'h1234, 5'd1);
    // R2 idle cycles carrying an overflowing add
    step(0, OP_ADD, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);
    step(0, OP_SUB, 32'h80000000, 32'h1, 16'h0, 5'd0);

    for (int n = 0; n < 3000; n++) begin
      step(($urandom_range(0, 7) != 0), 5'($urandom_range(0, 31)), pick(), pick(),
           16'($urandom()), 5'($urandom()));
    end

    in_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule